// File: doc/BRIEF.md
# Self-Synchronizing Serial Stream Cipher Datapath

This block encrypts or decrypts a serial bit stream, one bit per clock, with a self-synchronizing keystream. A 96-bit conditional-complement shift register absorbs the ciphertext stream. A seven-stage filter pipeline reduces that register to three bits, and their XOR is the keystream bit. Because the register is fed with ciphertext only, a receiver loaded with the same key follows the transmitter's state. After any disturbance it falls back into step once a bounded number of ciphertext bits have passed.

A one-cycle `start_i` pulse selects the mode (`mode_i` 0 = encrypt, 1 = decrypt) and opens a 105-cycle phase. During that phase the bits on `din_i` are an initialization vector that both ends share, and they are fed to the register in place of ciphertext. The data phase follows. The encryptor returns ciphertext in the same cycle as the plaintext it is given. The decryptor registers each ciphertext bit once and returns the plaintext one cycle later. Each storage cell on the feedback path is placed so that no register input is more than two XOR levels deep.

Top module: `selfsync_cipher`

## Requirements
- R1: After a `start_i` pulse in cycle S, the bits on `din_i` in cycles S+1 to S+105 are taken as the shared initialization vector, and `valid_o` is low in cycles S+1 to S+105. In encrypt mode `valid_o` rises in cycle S+106. In decrypt mode it rises in cycle S+107.
- R2: Out of reset, and in every cycle with `valid_o` low, `dout_o` is 0.
- R3: In encrypt mode, `dout_o` is `din_i` XOR the keystream in the same cycle. The ciphertext reaches the shift register through exactly one register. Changing only plaintext bit F therefore changes ciphertext bit F and leaves ciphertext bits F+1 to F+8 unchanged.
- R4: In decrypt mode, `din_i` is registered once, and `dout_o` in the next cycle is that registered bit XOR the keystream. The same bit passes a second register before it enters the shift register.
- R5: An encryptor and a decryptor that share the key and the initialization vector, with the decryptor fed the encryptor's output in the same cycle, reproduce every plaintext bit in order, each one cycle after it was encrypted.
- R6: If received ciphertext bit F is inverted, decrypted bit F is wrong, bits F+1 to F+8 are correct, and every bit from F+105 onward is correct.
- R7: `mode_i` is sampled only in the cycle in which `start_i` is high. Changes to it at any other time have no effect on the stream.
- R8: A decryptor that was loaded with a different initialization vector from the encryptor's delivers correct plaintext from data bit 104 onward.
- R9: Every key bit takes part. Inverting key bit 0 or key bit 95 changes the ciphertext for the same plaintext and initialization vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle pulse that begins the initialization-vector phase |
| mode_i | input | 1 | 0 = encrypt, 1 = decrypt; sampled with `start_i` |
| key_i | input | 96 | Cipher key, held stable during a stream |
| din_i | input | 1 | Initialization-vector bit, plaintext bit or ciphertext bit |
| dout_o | output | 1 | Ciphertext (encrypt) or plaintext (decrypt) |
| valid_o | output | 1 | `dout_o` carries a result bit |

## Verification
An encryptor and a decryptor run back to back. The plaintext patterns are all zeros, where the ciphertext is the raw keystream, all ones, alternating bits and a hashed pseudo-random pattern. A loss or shift of a bit anywhere on the round trip shows up in every one of these patterns. Two plaintexts that differ in a single bit expose the encrypt feedback delay through the exact set of ciphertext bits that change. A single inverted ciphertext bit exposes the decrypt delays and the memory length through the span of plaintext bits that go wrong. A mismatched initialization vector, a mode input that toggles during the stream, and inverted end key bits show that the vector is flushed, that the mode input is ignored outside `start_i`, and that both ends of the key are used.

// File: rtl/ssc_pkg.sv
package ssc_pkg;

  localparam int KEY_W    = 96;  // key bits
  localparam int NCELL    = 96;  // shift-register cells
  localparam int WIDE_W   = 53;  // width of the wide filter stages (odd)
  localparam int NMID     = 5;   // number of wide filter stages
  localparam int NARROW_W = 12;  // width of the compression stage
  localparam int NOUT     = 3;   // width of the last stage

  typedef enum logic [1:0] {PH_IDLE, PH_LOAD, PH_RUN} phase_t;

  // linear combiner
  function automatic logic f_lin(input logic a, input logic b, input logic c, input logic d);
    return a ^ b ^ c ^ d;
  endfunction

  // complementing combiner: a + b + c(d+1) + 1 over GF(2)
  function automatic logic f_cmp(input logic a, input logic b, input logic c, input logic d);
    return (a ^ b) ^ ((c & ~d) ^ 1'b1);
  endfunction

endpackage

// File: rtl/ssc_shiftreg.sv
module ssc_shiftreg
  import ssc_pkg::*;
#(
  parameter int NC = NCELL,
  parameter int KW = KEY_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          feed_i,
  input  logic [KW-1:0] key_i,
  output logic [NC:1]   cells_o
);

  logic [NC:0] tap;
  logic [NC:1] cell_d;
  logic [NC:1] cell_q;

  assign tap = {cell_q, feed_i};

  for (genvar j = 1; j <= NC; j++) begin : g_cell
    localparam int SEL3 = j % 3;
    localparam int SEL6 = j % 6;
    localparam int VI = (SEL3 == 1) ? (2 * (j - 1)) / 3 :
                        (SEL3 == 2) ? j - 4 :
                        (SEL6 == 3) ? 0 : j - 5;
    localparam int WI = (SEL6 == 0) ? 0 : j - 2;
    logic side_v;
    logic side_w;
    if (j <= 2) begin : g_edge
      assign side_v = 1'b0;
      assign side_w = 1'b0;
    end else begin : g_body
      assign side_v = tap[VI];
      assign side_w = tap[WI];
    end
    if (SEL3 == 1) begin : g_lin
      assign cell_d[j] = f_lin(tap[j-1], key_i[(j-1) % KW], side_v, side_w);
    end else begin : g_cmp
      assign cell_d[j] = f_cmp(tap[j-1], key_i[(j-1) % KW], side_v, side_w);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cell_q <= '0;
    else        cell_q <= cell_d;
  end

  assign cells_o = cell_q;

endmodule

// File: rtl/ssc_filter.sv
module ssc_filter
  import ssc_pkg::*;
#(
  parameter int NC = NCELL,
  parameter int WW = WIDE_W,
  parameter int NM = NMID,
  parameter int NW = NARROW_W,
  parameter int NO = NOUT
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [NC:1] cells_i,
  output logic        ks_o
);

  localparam int TAP_B = 18;
  localparam int TAP_C = 15;

  logic [NM-1:0][WW-1:0] mid_d, mid_q;
  logic [NW-1:0]         nar_d, nar_q;
  logic [NO-1:0]         out_d, out_q;

  // first wide stage reads the shift register, bit positions scattered by 4i mod WW
  for (genvar i = 0; i < WW; i++) begin : g_first
    localparam int IA = NC - i;
    localparam int IB = i + TAP_B;
    localparam int IC = NC - TAP_C - i;
    localparam int ID = i + 1;
    localparam bit OA = (IA >= 1) && (IA <= NC);
    localparam bit OB = (IB >= 1) && (IB <= NC);
    localparam bit OC = (IC >= 1) && (IC <= NC);
    localparam bit OD = (ID >= 1) && (ID <= NC);
    logic ta, tb, tc, td;
    assign ta = OA ? cells_i[OA ? IA : 1] : 1'b0;
    assign tb = OB ? cells_i[OB ? IB : 1] : 1'b0;
    assign tc = OC ? cells_i[OC ? IC : 1] : 1'b0;
    assign td = OD ? cells_i[OD ? ID : 1] : 1'b0;
    assign mid_d[0][(4 * i) % WW] = f_cmp(ta, tb, tc, td);
  end

  // remaining wide stages
  for (genvar m = 1; m < NM; m++) begin : g_mid
    for (genvar i = 0; i < WW; i++) begin : g_bit
      logic p0, p1, p2, p3;
      assign p0 = mid_q[m-1][i];
      if (i + 3 < WW) begin : g_full
        assign p1 = mid_q[m-1][i+1];
        assign p2 = mid_q[m-1][i+2];
        assign p3 = mid_q[m-1][i+3];
      end else begin : g_tail
        assign p1 = (i + 1 < WW) ? mid_q[m-1][(i + 1 < WW) ? i + 1 : i] : 1'b0;
        assign p2 = (i + 2 < WW) ? mid_q[m-1][(i + 2 < WW) ? i + 2 : i] : 1'b0;
        assign p3 = 1'b0;
      end
      assign mid_d[m][(4 * i) % WW] = f_cmp(p0, p3, p1, p2);
    end
  end

  // compression stages
  for (genvar i = 0; i < NW; i++) begin : g_nar
    assign nar_d[i] = f_cmp(mid_q[NM-1][4*i], mid_q[NM-1][4*i+3],
                            mid_q[NM-1][4*i+1], mid_q[NM-1][4*i+2]);
  end
  for (genvar i = 0; i < NO; i++) begin : g_out
    assign out_d[i] = f_lin(nar_q[4*i], nar_q[4*i+1], nar_q[4*i+2], nar_q[4*i+3]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mid_q <= '0;
      nar_q <= '0;
      out_q <= '0;
    end else begin
      mid_q <= mid_d;
      nar_q <= nar_d;
      out_q <= out_d;
    end
  end

  assign ks_o = ^out_q;

endmodule

// File: rtl/ssc_loadseq.sv
module ssc_loadseq
  import ssc_pkg::*;
#(
  parameter int LOAD_LEN = 105,
  localparam int CW = $clog2(LOAD_LEN + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic mode_i,
  output logic loading_o,
  output logic mode_o,
  output logic valid_o
);

  phase_t        ph_q, ph_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          mode_q, mode_d;
  logic          run_dly_q;

  always_comb begin
    ph_d   = ph_q;
    cnt_d  = cnt_q;
    mode_d = mode_q;
    if (start_i) begin
      ph_d   = PH_LOAD;
      cnt_d  = '0;
      mode_d = mode_i;
    end else if (ph_q == PH_LOAD) begin
      if (cnt_q == CW'(LOAD_LEN - 1)) ph_d  = PH_RUN;
      else                            cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q      <= PH_IDLE;
      cnt_q     <= '0;
      mode_q    <= 1'b0;
      run_dly_q <= 1'b0;
    end else begin
      ph_q      <= ph_d;
      cnt_q     <= cnt_d;
      mode_q    <= mode_d;
      run_dly_q <= (ph_q == PH_RUN);
    end
  end

  assign loading_o = (ph_q != PH_RUN);
  assign mode_o    = mode_q;
  // decrypt output trails its input register by one cycle
  assign valid_o   = (ph_q == PH_RUN) && (!mode_q || run_dly_q);

endmodule

// File: rtl/selfsync_cipher.sv
module selfsync_cipher
  import ssc_pkg::*;
#(
  parameter int KW = KEY_W,
  parameter int NC = NCELL,
  parameter int WW = WIDE_W,
  parameter int NM = NMID,
  parameter int NW = NARROW_W,
  parameter int NO = NOUT
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          mode_i,
  input  logic [KW-1:0] key_i,
  input  logic          din_i,
  output logic          dout_o,
  output logic          valid_o
);

  // feedback register + filter stages + two delay cells
  localparam int LOAD_LEN = NC + NM + 2 + 2;

  logic        loading;
  logic        mode_q;
  logic        ks;
  logic        rx_q;
  logic        fb_q, fb_d;
  logic        enc_bit;
  logic [NC:1] cells;

  ssc_loadseq #(.LOAD_LEN(LOAD_LEN)) i_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .mode_i   (mode_i),
    .loading_o(loading),
    .mode_o   (mode_q),
    .valid_o  (valid_o)
  );

  ssc_shiftreg #(.NC(NC), .KW(KW)) i_sr (
    .clk    (clk),
    .rst_n  (rst_n),
    .feed_i (fb_q),
    .key_i  (key_i),
    .cells_o(cells)
  );

  ssc_filter #(.NC(NC), .WW(WW), .NM(NM), .NW(NW), .NO(NO)) i_flt (
    .clk    (clk),
    .rst_n  (rst_n),
    .cells_i(cells),
    .ks_o   (ks)
  );

  // the initialization vector bypasses the keystream XOR
  assign enc_bit = loading ? din_i : (din_i ^ ks);
  assign fb_d    = mode_q ? rx_q : enc_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_q <= 1'b0;
      fb_q <= 1'b0;
    end else begin
      if (mode_q) rx_q <= din_i;
      fb_q <= fb_d;
    end
  end

  assign dout_o = valid_o & (mode_q ? (rx_q ^ ks) : (din_i ^ ks));

endmodule

// File: rtl/ssc_chk.sv
module ssc_chk #(
  parameter int LOAD_LEN = 105
) (
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic din_i,
  input logic dout_o,
  input logic valid_o,
  input logic mode_q,
  input logic fb_q
);

  logic [15:0] gap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        gap_q <= '0;
    else if (start_i)                  gap_q <= '0;
    else if (!valid_o && gap_q != '1)  gap_q <= gap_q + 1'b1;
  end

  AST_START_DROPS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> !valid_o); // R1

  AST_LOAD_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid_o) |-> (gap_q == (mode_q ? 16'(LOAD_LEN + 1) : 16'(LOAD_LEN)))); // R1

  AST_QUIET_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> (dout_o == 1'b0)); // R2

  AST_ENC_ONE_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !mode_q) |=> (fb_q == $past(dout_o))); // R3

  AST_DEC_TWO_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && mode_q) |-> (fb_q == $past(din_i, 2))); // R4

  AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> $stable(mode_q)); // R7

endmodule

bind selfsync_cipher ssc_chk i_ssc_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .start_i(start_i),
  .din_i  (din_i),
  .dout_o (dout_o),
  .valid_o(valid_o),
  .mode_q (mode_q),
  .fb_q   (fb_q)
);

// File: tb/test_selfsync_cipher.sv
module test_selfsync_cipher;

  localparam int LOAD  = 105;
  localparam int NDATA = 300;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tx_start = 1'b0, tx_mode = 1'b0, tx_din = 1'b0;
  logic        rx_start = 1'b0, rx_mode = 1'b1;
  logic        rx_sel = 1'b0, rx_flip = 1'b0, rx_iv = 1'b0;
  logic [95:0] tx_key, rx_key;
  logic        rx_din;
  logic        tx_dout, tx_valid, rx_dout, rx_valid;

  always #2 clk = ~clk;  // 250 MHz

  assign rx_din = rx_sel ? (tx_dout ^ rx_flip) : rx_iv;

  selfsync_cipher i_selfsync_cipher (
    .clk(clk), .rst_n(rst_n), .start_i(tx_start), .mode_i(tx_mode),
    .key_i(tx_key), .din_i(tx_din), .dout_o(tx_dout), .valid_o(tx_valid));

  selfsync_cipher i_selfsync_cipher_rx (
    .clk(clk), .rst_n(rst_n), .start_i(rx_start), .mode_i(rx_mode),
    .key_i(rx_key), .din_i(rx_din), .dout_o(rx_dout), .valid_o(rx_valid));

  int    checks = 0, errors = 0, cyc = 0, skip_diffs = 0;
  bit    active = 1'b0;
  string cur_tag = "R5";
  bit    exp_q[$];
  int    cls_q[$];    // 0 must match, 1 free, 2 must differ
  bit    ct_log[NDATA];
  bit    ct_ref[NDATA];

  localparam logic [95:0]  KEY_A = 96'h3A5C_91E7_0D24_B6F8_1C7E_5A93;
  localparam logic [104:0] IV_A  = {9'h1B3, 96'hC4F0_2E91_7A6D_58B3_0F1C_E247};
  localparam logic [104:0] IV_B  = {9'h04E, 96'h19D3_A7C2_6E05_F8B4_932A_710D};

  task automatic check(input bit ok, input string tag, input string what,
                       input logic act, input logic exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
    end
  endtask

  function automatic bit pt_bit(input int pat, input int n);
    int unsigned h;
    h = 32'(n) * 32'h9E37_79B1;
    case (pat)
      0:       return 1'b0;
      1:       return 1'b1;
      2:       return n[0];
      default: return h[17] ^ h[5];
    endcase
  endfunction

  // monitor: scoreboard of decrypted bits
  always @(negedge clk) begin
    if (active && rx_valid && exp_q.size() > 0) begin
      bit e;
      int c;
      e = exp_q.pop_front();
      c = cls_q.pop_front();
      if (c == 1) begin
        if (rx_dout !== e) skip_diffs++;
      end else if (c == 2) begin
        check(rx_dout !== e, cur_tag, "corrupted bit must decrypt wrong", rx_dout, ~e);
      end else begin
        check(rx_dout === e, cur_tag, "decrypted bit", rx_dout, e);
      end
    end
  end

  // driver
  task automatic run_stream(input logic [95:0] ke, input logic [95:0] kd,
                            input logic [104:0] ive, input logic [104:0] ivd,
                            input int pat, input int pflip, input int cflip,
                            input bit tog, input bit ivfree);
    bit load_ok;
    tx_key = ke;  rx_key = kd;
    skip_diffs = 0;
    active = 1'b1;
    tx_mode = 1'b0; rx_mode = 1'b1;
    tx_start = 1'b1; rx_start = 1'b1;
    rx_sel = 1'b0; rx_flip = 1'b0;
    @(negedge clk);
    tx_start = 1'b0; rx_start = 1'b0;
    load_ok = 1'b1;
    for (int k = 0; k < LOAD; k++) begin
      if (tx_valid || rx_valid) load_ok = 1'b0;
      if (tog) begin tx_mode = k[0]; rx_mode = ~k[0]; end
      tx_din = ive[k];
      rx_iv  = ivd[k];
      @(negedge clk);
    end
    check(load_ok, "R1", "valid low during vector load", tx_valid | rx_valid, 1'b0);
    for (int n = 0; n < NDATA; n++) begin
      bit p;
      int c;
      if (n == 0) begin
        check(tx_valid === 1'b1, "R1", "encrypt valid at cycle S+106", tx_valid, 1'b1);
        check(rx_valid === 1'b0, "R1", "decrypt valid low at cycle S+106", rx_valid, 1'b0);
      end
      if (n == 1)
        check(rx_valid === 1'b1, "R1", "decrypt valid at cycle S+107", rx_valid, 1'b1);
      if (tog) begin tx_mode = n[0]; rx_mode = ~n[0]; end
      p = pt_bit(pat, n) ^ (n == pflip);
      c = 0;
      if (cflip >= 0) begin
        if (n == cflip) c = 2;
        else if (n >= cflip + 9 && n <= cflip + 104) c = 1;
      end
      if (ivfree && n < 104) c = 1;
      tx_din  = p;
      rx_sel  = 1'b1;
      rx_flip = (n == cflip);
      exp_q.push_back(p);
      cls_q.push_back(c);
      #1;
      ct_log[n] = tx_dout;
      @(negedge clk);
    end
    rx_flip = 1'b0;
    repeat (2) @(negedge clk);
    active = 1'b0;
    check(exp_q.size() == 0, "R5", "every plaintext bit came back", exp_q.size() == 0, 1'b1);
    exp_q.delete();
    cls_q.delete();
  endtask

  task automatic cmp_ct(input int lo, input int hi, input string tag, input string what);
    for (int n = lo; n <= hi; n++)
      check(ct_log[n] === ct_ref[n], tag, what, ct_log[n], ct_ref[n]);
  endtask

  initial begin
    int diffs;
    tx_key = KEY_A; rx_key = KEY_A;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R2: reset state, input activity before any start
    tx_din = 1'b1;
    #1;
    check(tx_valid === 1'b0 && rx_valid === 1'b0, "R2", "valid after reset", tx_valid | rx_valid, 1'b0);
    check(tx_dout === 1'b0, "R2", "encrypt output quiet before start", tx_dout, 1'b0);
    check(rx_dout === 1'b0, "R2", "decrypt output quiet before start", rx_dout, 1'b0);
    @(negedge clk);

    cur_tag = "R5";
    run_stream(KEY_A, KEY_A, IV_A, IV_A, 0, -1, -1, 1'b0, 1'b0);
    run_stream(KEY_A, KEY_A, IV_A, IV_A, 1, -1, -1, 1'b0, 1'b0);
    run_stream(KEY_A, KEY_A, IV_B, IV_B, 2, -1, -1, 1'b0, 1'b0);
    run_stream(KEY_A, KEY_A, IV_A, IV_A, 3, -1, -1, 1'b0, 1'b0);
    ct_ref = ct_log;

    // R3: one plaintext bit changed at index 40
    cur_tag = "R3";
    run_stream(KEY_A, KEY_A, IV_A, IV_A, 3, 40, -1, 1'b0, 1'b0);
    cmp_ct(0, 39, "R3", "ciphertext before changed bit");
    check(ct_log[40] !== ct_ref[40], "R3", "ciphertext of changed bit", ct_log[40], ~ct_ref[40]);
    cmp_ct(41, 48, "R3", "ciphertext inside keystream delay");

    // R6: one ciphertext bit inverted in transit at index 50
    cur_tag = "R6";
    run_stream(KEY_A, KEY_A, IV_A, IV_A, 3, -1, 50, 1'b0, 1'b0);

    // R8: receiver loaded with a different vector
    cur_tag = "R8";
    run_stream(KEY_A, KEY_A, IV_A, IV_B, 3, -1, -1, 1'b0, 1'b1);
    check(skip_diffs > 0, "R8", "vector mismatch visible before resync", skip_diffs > 0, 1'b1);

    // R7: mode inputs toggle outside start
    cur_tag = "R7";
    run_stream(KEY_A, KEY_A, IV_A, IV_A, 3, -1, -1, 1'b1, 1'b0);
    cmp_ct(0, NDATA - 1, "R7", "ciphertext unchanged by mode toggling");

    // R9: end key bits
    cur_tag = "R9";
    run_stream(KEY_A ^ 96'h1, KEY_A ^ 96'h1, IV_A, IV_A, 3, -1, -1, 1'b0, 1'b0);
    diffs = 0;
    for (int n = 0; n < NDATA; n++) if (ct_log[n] !== ct_ref[n]) diffs++;
    check(diffs > 0, "R9", "key bit 0 changes ciphertext", diffs > 0, 1'b1);
    run_stream(KEY_A ^ (96'h1 << 95), KEY_A ^ (96'h1 << 95), IV_A, IV_A, 3, -1, -1, 1'b0, 1'b0);
    diffs = 0;
    for (int n = 0; n < NDATA; n++) if (ct_log[n] !== ct_ref[n]) diffs++;
    check(diffs > 0, "R9", "key bit 95 changes ciphertext", diffs > 0, 1'b1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++;
      errors++;
      $display("FAIL watchdog run did not complete actual=%0d expected=%0d", cyc, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule